// File: doc/BRIEF.md
# Round-Robin Request/Grant Bus Arbiter

This block is the single, central arbiter for a shared parallel bus with up to N initiators. Every initiator has a private active-low request line and a private active-low grant line. All requests are examined together on every clock, and the next owner is picked in rotating order so that no requester is favoured.

Arbitration is hidden behind data movement. The arbiter watches the start-of-cycle strobe and the initiator-ready strobe. While one initiator is still in its burst, the grant may already be taken from it and handed to the next winner. The newly granted initiator starts its own transaction only on a clock where both strobes are high, which means the bus is idle. When nobody requests, the grant stays parked on the last owner, so that initiator can start again without waiting for arbitration.

Top module: `rr_bus_arbiter`

## Requirements
- R1: The grant output `gnt_n` is active low, and at most one of its bits is low on any clock.
- R2: While `rst_n` is low, every bit of `gnt_n` is high. The first clock after reset grants the round-robin winner searched from master 1, or parks on master 0 if no request is low.
- R3: When no grant is active and some request is low, the next grant goes to the first requesting master after the most recently granted one, in rising index order with wrap-around. This is visible one clock later.
- R4: A grant never moves straight from one master to another. Every handoff has exactly one clock with all of `gnt_n` high, and the new grant follows on the next clock.
- R5: When no request line is low, the grant stays on, or returns to, the most recently granted master.
- R6: A master whose request is low and whose grant is low keeps its grant until it has started a transaction. A start is a clock with `frame_n` low that immediately follows a clock on which that master was granted and both `frame_n` and `irdy_n` were high.
- R7: Once the granted master has started, its grant may be removed for another requester even while `frame_n` is still low. In that case the arbitration overlaps the ongoing burst.
- R8: A granted master that has started, or that no longer requests, keeps its grant while no other master is requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | N | Per-master request, active low |
| frame_n | input | 1 | Start-of-cycle strobe of the shared bus, active low |
| irdy_n | input | 1 | Initiator-ready strobe of the shared bus, active low |
| gnt_n | output | N | Per-master grant, active low, at most one low |

## Verification
On every clock, the assertions check four things: the grant is one-hot or empty, a handoff always passes through an all-high clock, that gap lasts exactly one clock, and the grant holds while requests are absent. They also check that a requesting master loses its grant only after the start-of-cycle strobe was seen low during that grant. The exact rotating order of winners, and the choice to move the grant in the middle of a burst rather than waiting, are shown only by the bench. The bench compares every clock against its own arbitration model, under directed and random request and strobe patterns.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic {
      GRANT_OFF = 1'b0,
      GRANT_ON  = 1'b1
   } grant_state_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          found,
   output logic [IW-1:0] win
);
   // Search from last+1 upward with wrap; the descending loop lets the
   // nearest candidate overwrite farther ones.
   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int k = N; k >= 1; k--) begin
         int cand;
         cand = (int'(last) + k) % N;
         if (req[cand]) begin
            found = 1'b1;
            win   = IW'(cand);
         end
      end
   end
endmodule

// File: rtl/start_track.sv
module start_track (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_on,
   input  logic hold,
   input  logic frame_n,
   input  logic irdy_n,
   output logic started
);
   logic armed_q;
   logic started_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         started_q <= 1'b0;
      end else begin
         // idle clock seen while a grant is held: owner may start next clock
         armed_q   <= grant_on & frame_n & irdy_n;
         started_q <= hold ? (started_q | (armed_q & ~frame_n)) : 1'b0;
      end
   end

   assign started = started_q;
endmodule

// File: rtl/grant_ctrl.sv
module grant_ctrl
   import arb_pkg::*;
#(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          found,
   input  logic [IW-1:0] win,
   input  logic          started,
   output logic          grant_on,
   output logic [IW-1:0] owner,
   output logic [IW-1:0] last,
   output logic          hold
);
   grant_state_e  st_q;
   logic [IW-1:0] owner_q;
   logic [IW-1:0] last_q;
   logic          keep_own;
   logic          drop;

   assign keep_own = req[owner_q] & ~started;
   assign drop     = (st_q == GRANT_ON) & ~keep_own & found & (win != owner_q);
   assign hold     = (st_q == GRANT_ON) & ~drop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= GRANT_OFF;
         owner_q <= '0;
         last_q  <= '0;
      end else if (st_q == GRANT_OFF) begin
         st_q <= GRANT_ON;
         if (found) begin
            owner_q <= win;
            last_q  <= win;
         end else begin
            owner_q <= last_q;
         end
      end else if (drop) begin
         st_q <= GRANT_OFF;
      end
   end

   assign grant_on = (st_q == GRANT_ON);
   assign owner    = owner_q;
   assign last     = last_q;
endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_n,
   input  logic         frame_n,
   input  logic         irdy_n,
   output logic [N-1:0] gnt_n
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_n
      $error("rr_bus_arbiter: N must be at least 2");
   end

   logic [N-1:0]  req;
   logic          found;
   logic [IW-1:0] win;
   logic [IW-1:0] last;
   logic [IW-1:0] owner;
   logic          grant_on;
   logic          hold;
   logic          started;

   assign req = ~req_n;

   rr_pick #(.N(N), .IW(IW)) u_pick (
      .req   (req),
      .last  (last),
      .found (found),
      .win   (win)
   );

   grant_ctrl #(.N(N), .IW(IW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .found    (found),
      .win      (win),
      .started  (started),
      .grant_on (grant_on),
      .owner    (owner),
      .last     (last),
      .hold     (hold)
   );

   start_track u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant_on (grant_on),
      .hold     (hold),
      .frame_n  (frame_n),
      .irdy_n   (irdy_n),
      .started  (started)
   );

   for (genvar i = 0; i < N; i++) begin : g_gnt
      assign gnt_n[i] = ~(grant_on & (owner == IW'(i)));
   end
endmodule

// File: rtl/rr_bus_arbiter_chk.sv
module rr_bus_arbiter_chk #(
   parameter int N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] req_n,
   input logic         frame_n,
   input logic [N-1:0] gnt_n
);
   localparam logic [N-1:0] ONES = '1;

   logic seen_frame;
   always_ff @(posedge clk) begin
      if (!rst_n)              seen_frame <= 1'b0;
      else if (gnt_n == ONES)  seen_frame <= 1'b0;
      else if (!frame_n)       seen_frame <= 1'b1;
   end

   // R1
   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~gnt_n));

   // R4: no direct hop between two masters
   p_no_hop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_n != ONES && $past(gnt_n) != ONES) |-> gnt_n == $past(gnt_n));

   // R4: the all-high gap lasts one clock
   p_gap_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_n == ONES && $past(gnt_n) != ONES) |=> gnt_n != ONES);

   // R5
   p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_n != ONES && req_n == ONES) |=> gnt_n == $past(gnt_n));

   // R6: a requesting owner loses its grant only after starting
   p_no_starve_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(gnt_n) != ONES && gnt_n == ONES && $past((~req_n & ~gnt_n) != '0))
      |-> $past(seen_frame));
endmodule

bind rr_bus_arbiter rr_bus_arbiter_chk #(.N(N)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_n   (req_n),
   .frame_n (frame_n),
   .gnt_n   (gnt_n)
);

// File: tb/rr_bus_arbiter_bench.sv
module rr_bus_arbiter_bench;
   localparam int N     = 4;
   localparam int CLK_P = 10;
   localparam int RUN   = 3200;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req_n = '1;
   logic         frame_n = 1'b1;
   logic         irdy_n = 1'b1;
   logic [N-1:0] gnt_n;

   int checks = 0;
   int fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   rr_bus_arbiter #(.N(N)) u_rr_bus_arbiter (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_n   (req_n),
      .frame_n (frame_n),
      .irdy_n  (irdy_n),
      .gnt_n   (gnt_n)
   );

   // reference model state
   bit    m_on = 0;
   int    m_idx = 0;
   int    m_last = 0;
   bit    m_armed = 0;
   bit    m_started = 0;
   string m_tag = "R2";

   function automatic int rr(logic [N-1:0] r, int last);
      for (int k = 1; k <= N; k++) begin
         if (r[(last + k) % N]) return (last + k) % N;
      end
      return -1;
   endfunction

   function automatic logic [N-1:0] expect_gnt(bit on, int idx);
      logic [N-1:0] v;
      v = '1;
      if (on) v[idx] = 1'b0;
      return v;
   endfunction

   always @(posedge clk) begin
      logic [N-1:0] r;
      int  w;
      bit  drop, n_started, n_armed;
      if (!rst_n) begin
         m_on = 0; m_idx = 0; m_last = 0; m_armed = 0; m_started = 0;
         m_tag = "R2";
      end else begin
         r = ~req_n;
         w = rr(r, m_last);
         drop = m_on && !(r[m_idx] && !m_started) && (w >= 0) && (w != m_idx);
         n_started = (m_on && !drop) ? (m_started | (m_armed & ~frame_n)) : 1'b0;
         n_armed   = m_on & frame_n & irdy_n;
         if (!m_on)                   m_tag = (w >= 0) ? "R3" : "R5";
         else if (drop)               m_tag = frame_n ? "R4" : "R7";
         else if (r == '0)            m_tag = "R5";
         else if (r[m_idx] && !m_started && w >= 0 && w != m_idx) m_tag = "R6";
         else                         m_tag = "R8";
         if (!m_on) begin
            m_on = 1;
            if (w >= 0) begin m_idx = w; m_last = w; end
            else m_idx = m_last;
         end else if (drop) begin
            m_on = 0;
         end
         m_started = n_started;
         m_armed   = n_armed;
      end
   end

   task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: gnt_n actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   initial begin
      int dens;
      void'($urandom(32'd1234));
      dens = 50;
      repeat (3) @(negedge clk);
      chk("R2", gnt_n, '1);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < RUN; cyc++) begin
         @(negedge clk);
         chk(m_tag, gnt_n, expect_gnt(m_on, m_idx));
         checks++;
         if ($countones(~gnt_n) > 1) begin
            fails++;
            $display("FAIL R1: gnt_n actual %b expected at most one low", gnt_n);
         end
         if (cyc < 10) begin
            // directed: nobody requests, grant parks on master 0
            req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
         end else if (cyc < 30) begin
            // directed: all request, nobody starts -> owner kept
            req_n = '0; frame_n = 1'b1; irdy_n = 1'b1;
         end else if (cyc < 90) begin
            // directed: all request, owners start on alternate clocks
            req_n = '0; frame_n = cyc[0]; irdy_n = cyc[0];
         end else begin
            if (cyc % 200 == 0) begin
               case (($urandom % 4))
                  0: dens = 0;
                  1: dens = 25;
                  2: dens = 50;
                  default: dens = 90;
               endcase
            end
            for (int i = 0; i < N; i++) req_n[i] = !(($urandom % 100) < dens);
            frame_n = ($urandom % 100) >= 40;
            irdy_n  = ($urandom % 2) == 0;
         end
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule